// File: doc/BRIEF.md
# Power Domain Sequencer

This block switches a small set of power domains on and off in hardware. Each domain owns a group of bits in three shared 32-bit control words. The first is a power-down word, where 1 removes power. The second is an isolation word, which is active-low: 0 clamps the domain's outputs. The third is a reset word, also active-low: 0 holds the domain in reset. A one-cycle request strobe for a domain, together with a target direction, starts a three-step sequence. To turn a domain off, the sequence clamps the isolators, then asserts reset, then removes power. To turn it on, it restores power, then releases reset, then opens the isolators. After each step the sequence waits a programmable number of cycles before the next step.

The masks that tie each domain to its bits are fixed by parameters. A zero isolation or reset mask means that step is skipped, while the power step always runs. Requests wait in a per-domain pending flag. They are served one domain at a time, and the lowest domain index goes first.

A simple single-cycle register bus gives software direct access to the three control words and to the step delay. The bus can also pulse a single reset line low for one cycle. For each domain the block reports whether it is busy and whether it is currently powered.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the power-down word is 0x00000000, the isolation word is 0xFFFFFFFF, the reset word is 0xFFFFFFFF and the step delay is 4; every domain reads as powered and none as busy.
- R2: Bus offsets are 0x10 for power-down, 0x30 for reset, 0x58 for isolation and 0x20 for the step delay (low 8 bits). A write takes effect at the clock edge that samples it. A read returns the current value in the same cycle. Any other offset reads 0.
- R3: A power-off request for a domain first clears its isolation bits, then clears its reset bits, and last sets its power-down bits.
- R4: A power-on request for a domain first clears its power-down bits, then sets its reset bits, and last sets its isolation bits.
- R5: When no step is skipped, consecutive steps of one sequence change the registers exactly D+1 cycles apart, where D is the programmed delay (D=0 gives back-to-back steps).
- R6: A domain whose isolation mask or reset mask is zero skips that step, so those words are not touched; its power step still runs.
- R7: A sequence changes only the bits inside the served domain's masks; every other bit of the three words keeps its value.
- R8: Only one domain is sequenced at a time. When several requests are pending, the lowest domain index is served first, and the next domain's first step comes after the previous sequence has finished.
- R9: A request whose target already matches the domain's power-down bits (all clear for on, all set for off) completes without changing any register, and busy drops within three cycles.
- R10: A domain reads as powered exactly when all of its power-down bits are 0, whether those bits were written by a sequence or over the bus.
- R11: A bus write to offset 0x34 with a line number in bits [4:0] drives that reset bit to 0 for exactly one cycle and then back to 1, leaving all other reset bits unchanged.
- R12: A domain's busy output is high from the cycle after its request until its sequence has finished, including the wait after the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| req_vld | input | NUM_DOM | One-cycle request strobe per domain |
| req_on | input | NUM_DOM | Target per domain: 1 = power on, 0 = power off |
| pwr_dn_o | output | 32 | Power-down word (1 = unpowered) |
| iso_n_o | output | 32 | Isolation word (0 = isolators clamped) |
| rst_n_o | output | 32 | Reset word (0 = held in reset) |
| dom_busy | output | NUM_DOM | Domain has a pending or running request |
| dom_powered | output | NUM_DOM | All power-down bits of the domain are 0 |

## Verification
The ordering properties assume two things about the bus. First, it does not rewrite a domain's isolation, reset or power bits while that domain is being sequenced. Second, the reset pulse is never aimed at a line that belongs to a running domain. The domain masks are also assumed not to overlap. The bench keeps all bus traffic, including delay changes, between sequences. It pulses only a reset line that no domain owns. It sweeps every domain in both directions over delays 0 to 4, and runs the priority, already-in-state and pulse cases separately.

// File: rtl/pds_pkg.sv
// Package: shared constants and types for the power domain sequencer.
// Assumes a 32-bit control word and byte offsets that fit in 8 bits.
package pds_pkg;
    localparam int REG_W   = 32;
    localparam int LINE_W  = $clog2(REG_W);

    localparam logic [7:0] OFS_PWR   = 8'h10;
    localparam logic [7:0] OFS_DLY   = 8'h20;
    localparam logic [7:0] OFS_RST   = 8'h30;
    localparam logic [7:0] OFS_PULSE = 8'h34;
    localparam logic [7:0] OFS_ISO   = 8'h58;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_STEP = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    // Bit-level set/clear requests from the sequencer to the register file.
    typedef struct packed {
        logic [REG_W-1:0] set_pwr;
        logic [REG_W-1:0] clr_pwr;
        logic [REG_W-1:0] set_iso;
        logic [REG_W-1:0] clr_iso;
        logic [REG_W-1:0] set_rst;
        logic [REG_W-1:0] clr_rst;
    } reg_upd_t;
endpackage

// File: rtl/pds_regfile.sv
// Module: control words, step delay and reset-pulse logic.
// The bus write is applied first and the sequencer's masked set/clear on top
// of it, so a sequencer step in the same cycle wins on its own bits.
// Assumes a single-cycle bus with no wait states.
module pds_regfile
    import pds_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DLY_W   = 8,
    parameter int DEF_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  reg_upd_t          upd,
    output logic [REG_W-1:0]  pwr_q,
    output logic [REG_W-1:0]  iso_q,
    output logic [REG_W-1:0]  rst_q,
    output logic [DLY_W-1:0]  dly_q
);
    logic              wr_pwr, wr_iso, wr_rst, wr_dly, wr_pulse;
    logic [REG_W-1:0]  pwr_nx, iso_nx, rst_nx;
    logic              pulse_pend_q;
    logic [LINE_W-1:0] pulse_line_q;

    // Purpose: decode the write strobes per register.
    always_comb begin
        wr_pwr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_PWR));
        wr_iso   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ISO));
        wr_rst   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_RST));
        wr_dly   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DLY));
        wr_pulse = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_PULSE));
    end

    // Purpose: merge bus writes, pulse restore/clear and sequencer updates.
    always_comb begin
        pwr_nx = wr_pwr ? bus_wdata : pwr_q;
        iso_nx = wr_iso ? bus_wdata : iso_q;
        rst_nx = wr_rst ? bus_wdata : rst_q;
        if (pulse_pend_q) rst_nx[pulse_line_q] = 1'b1;
        if (wr_pulse)     rst_nx[bus_wdata[LINE_W-1:0]] = 1'b0;
        pwr_nx = (pwr_nx & ~upd.clr_pwr) | upd.set_pwr;
        iso_nx = (iso_nx & ~upd.clr_iso) | upd.set_iso;
        rst_nx = (rst_nx & ~upd.clr_rst) | upd.set_rst;
    end

    // Purpose: hold the control words; reset leaves every domain running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= '0;
            iso_q <= '1;
            rst_q <= '1;
        end else begin
            pwr_q <= pwr_nx;
            iso_q <= iso_nx;
            rst_q <= rst_nx;
        end
    end

    // Purpose: hold the programmable step delay.
    always_ff @(posedge clk) begin
        if (!rst_n)      dly_q <= DLY_W'(DEF_DLY);
        else if (wr_dly) dly_q <= bus_wdata[DLY_W-1:0];
    end

    // Purpose: remember a reset pulse so the line is released one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_pend_q <= 1'b0;
            pulse_line_q <= '0;
        end else begin
            pulse_pend_q <= wr_pulse;
            if (wr_pulse) pulse_line_q <= bus_wdata[LINE_W-1:0];
        end
    end

    // Purpose: combinational read mux; unmapped offsets read 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_PWR))      bus_rdata = pwr_q;
            else if (bus_addr == ADDR_W'(OFS_ISO)) bus_rdata = iso_q;
            else if (bus_addr == ADDR_W'(OFS_RST)) bus_rdata = rst_q;
            else if (bus_addr == ADDR_W'(OFS_DLY)) bus_rdata = REG_W'(dly_q);
        end
    end
endmodule

// File: rtl/pds_arbiter.sv
// Module: per-domain pending flags and fixed-priority grant (lowest index).
// A grant is issued only while the sequencer is idle and clears the pending
// flag at once; a new strobe in the same cycle keeps the flag set.
module pds_arbiter #(
    parameter int NUM_DOM = 3,
    parameter int DOM_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] req_vld,
    input  logic [NUM_DOM-1:0] req_on,
    input  logic               seq_idle,
    output logic               grant_vld,
    output logic [DOM_W-1:0]   grant_idx,
    output logic               grant_on,
    output logic [NUM_DOM-1:0] pend_q
);
    logic [NUM_DOM-1:0] tgt_q;
    logic               any_pend;

    // Purpose: find the lowest-index pending domain.
    always_comb begin
        any_pend  = 1'b0;
        grant_idx = '0;
        for (int i = NUM_DOM - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                any_pend  = 1'b1;
                grant_idx = DOM_W'(i);
            end
        end
        grant_vld = any_pend && seq_idle;
        grant_on  = tgt_q[grant_idx];
    end

    // Purpose: capture requests and retire them when granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            tgt_q  <= '0;
        end else begin
            for (int i = 0; i < NUM_DOM; i++) begin
                if (req_vld[i]) begin
                    pend_q[i] <= 1'b1;
                    tgt_q[i]  <= req_on[i];
                end else if (grant_vld && (grant_idx == DOM_W'(i))) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pds_sequencer.sv
// Module: three-step power sequence engine for one domain at a time.
// Off order: clamp isolation, assert reset, set power-down.
// On order: clear power-down, release reset, open isolation.
// A step with a zero mask is skipped in one cycle without a wait.
// Assumes non-overlapping masks and a non-zero power mask per domain.
module pds_sequencer
    import pds_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int DOM_W   = 2,
    parameter int DLY_W   = 8,
    parameter logic [NUM_DOM-1:0][REG_W-1:0] PWR_MASK = '0,
    parameter logic [NUM_DOM-1:0][REG_W-1:0] ISO_MASK = '0,
    parameter logic [NUM_DOM-1:0][REG_W-1:0] RST_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_vld,
    input  logic [DOM_W-1:0]   grant_idx,
    input  logic               grant_on,
    input  logic [REG_W-1:0]   pwr_q,
    input  logic [DLY_W-1:0]   dly_q,
    output reg_upd_t           upd,
    output logic               seq_idle,
    output logic [NUM_DOM-1:0] act_vec
);
    sq_state_e        st_q;
    logic [DOM_W-1:0] dom_q;
    logic             on_q;
    logic [1:0]       step_q;
    logic [DLY_W-1:0] cnt_q;
    logic [REG_W-1:0] pm, im, rm, gp, step_mask;
    logic             already, last_step;

    // Purpose: look up the masks of the served and the granted domain.
    always_comb begin
        pm = PWR_MASK[dom_q];
        im = ISO_MASK[dom_q];
        rm = RST_MASK[dom_q];
        gp = PWR_MASK[grant_idx];
        already = grant_on ? ((pwr_q & gp) == '0) : ((pwr_q & gp) == gp);
        last_step = (step_q == 2'd2);
    end

    // Purpose: choose the mask and the set/clear action of the current step.
    always_comb begin
        upd       = '0;
        step_mask = '0;
        case ({on_q, step_q})
            3'b0_00: begin step_mask = im; upd.clr_iso = im; end
            3'b0_01: begin step_mask = rm; upd.clr_rst = rm; end
            3'b0_10: begin step_mask = pm; upd.set_pwr = pm; end
            3'b1_00: begin step_mask = pm; upd.clr_pwr = pm; end
            3'b1_01: begin step_mask = rm; upd.set_rst = rm; end
            3'b1_10: begin step_mask = im; upd.set_iso = im; end
            default: step_mask = '0;
        endcase
        if (st_q != SQ_STEP) upd = '0;
    end

    // Purpose: step through the sequence, waiting the delay after each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            dom_q  <= '0;
            on_q   <= 1'b0;
            step_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (grant_vld && !already) begin
                        dom_q  <= grant_idx;
                        on_q   <= grant_on;
                        step_q <= '0;
                        st_q   <= SQ_STEP;
                    end
                end
                SQ_STEP: begin
                    if ((step_mask != '0) && (dly_q != '0)) begin
                        cnt_q <= dly_q - 1'b1;
                        st_q  <= SQ_WAIT;
                    end else if (last_step) begin
                        st_q <= SQ_IDLE;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (last_step) begin
                        st_q <= SQ_IDLE;
                    end else begin
                        step_q <= step_q + 1'b1;
                        st_q   <= SQ_STEP;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Purpose: idle flag and one-hot view of the domain in service.
    always_comb begin
        seq_idle = (st_q == SQ_IDLE);
        for (int i = 0; i < NUM_DOM; i++)
            act_vec[i] = !seq_idle && (dom_q == DOM_W'(i));
    end
endmodule

// File: rtl/pwr_domain_seq.sv
// Module: top of the power domain sequencer.
// Connects the register file, the request arbiter and the sequencer, and
// derives per-domain busy and powered status.
// Assumes the masks of different domains do not overlap.
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int ADDR_W  = 8,
    parameter int DLY_W   = 8,
    parameter int DEF_DLY = 4,
    parameter logic [NUM_DOM-1:0][31:0] PWR_MASK = {32'h0000_0001, 32'h0000_0004, 32'h0000_0008},
    parameter logic [NUM_DOM-1:0][31:0] ISO_MASK = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001},
    parameter logic [NUM_DOM-1:0][31:0] RST_MASK = {32'h0000_0000, 32'h0004_0000, 32'h0001_0000}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_DOM-1:0] req_vld,
    input  logic [NUM_DOM-1:0] req_on,
    output logic [31:0]        pwr_dn_o,
    output logic [31:0]        iso_n_o,
    output logic [31:0]        rst_n_o,
    output logic [NUM_DOM-1:0] dom_busy,
    output logic [NUM_DOM-1:0] dom_powered
);
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;

    reg_upd_t           upd;
    logic [DLY_W-1:0]   dly_q;
    logic               seq_idle, grant_vld, grant_on;
    logic [DOM_W-1:0]   grant_idx;
    logic [NUM_DOM-1:0] pend_q, act_vec;

    pds_regfile #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .DEF_DLY(DEF_DLY)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd(upd), .pwr_q(pwr_dn_o), .iso_q(iso_n_o), .rst_q(rst_n_o),
        .dly_q(dly_q)
    );

    pds_arbiter #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_on(req_on),
        .seq_idle(seq_idle), .grant_vld(grant_vld), .grant_idx(grant_idx),
        .grant_on(grant_on), .pend_q(pend_q)
    );

    pds_sequencer #(
        .NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .DLY_W(DLY_W),
        .PWR_MASK(PWR_MASK), .ISO_MASK(ISO_MASK), .RST_MASK(RST_MASK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld),
        .grant_idx(grant_idx), .grant_on(grant_on), .pwr_q(pwr_dn_o),
        .dly_q(dly_q), .upd(upd), .seq_idle(seq_idle), .act_vec(act_vec)
    );

    // Purpose: per-domain status from pending/active state and power bits.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_status
        assign dom_busy[d]    = pend_q[d] | act_vec[d];
        assign dom_powered[d] = ((pwr_dn_o & PWR_MASK[d]) == '0);
    end
endmodule

// File: rtl/pds_checker.sv
// Module: assertion checker for pwr_domain_seq, attached by bind.
// Assumes no bus rewrite of a domain's bits while it is sequenced.
module pds_checker #(
    parameter int NUM_DOM = 3,
    parameter int ADDR_W  = 8,
    parameter logic [NUM_DOM-1:0][31:0] PWR_MASK = '0,
    parameter logic [NUM_DOM-1:0][31:0] ISO_MASK = '0,
    parameter logic [NUM_DOM-1:0][31:0] RST_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        pwr_dn_o,
    input logic [31:0]        iso_n_o,
    input logic [31:0]        rst_n_o,
    input logic [NUM_DOM-1:0] act_vec,
    input logic [NUM_DOM-1:0] dom_busy
);
    function automatic logic [31:0] or_all(input logic [NUM_DOM-1:0][31:0] m);
        logic [31:0] r = '0;
        for (int i = 0; i < NUM_DOM; i++) r |= m[i];
        return r;
    endfunction

    localparam logic [31:0] ALL_P = or_all(PWR_MASK);
    localparam logic [31:0] ALL_I = or_all(ISO_MASK);

    logic bw_pwr, bw_iso;
    assign bw_pwr = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h10));
    assign bw_iso = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h58));

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pwr_dn_o == '0 && iso_n_o == '1 && rst_n_o == '1));

    p_single_domain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_vec));

    p_pwr_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bw_pwr) |-> ((pwr_dn_o & ~ALL_P) == ($past(pwr_dn_o) & ~ALL_P)));

    p_iso_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bw_iso) |-> ((iso_n_o & ~ALL_I) == ($past(iso_n_o) & ~ALL_I)));

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        p_off_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwr_dn_o & PWR_MASK[d]) == PWR_MASK[d]) &&
            (($past(pwr_dn_o) & PWR_MASK[d]) != PWR_MASK[d]) && !$past(bw_pwr)
            |-> ((iso_n_o & ISO_MASK[d]) == '0 && (rst_n_o & RST_MASK[d]) == '0));

        p_busy_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
            act_vec[d] |-> dom_busy[d]);

        if (ISO_MASK[d] != '0) begin : g_iso
            p_on_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ((iso_n_o & ISO_MASK[d]) == ISO_MASK[d]) &&
                (($past(iso_n_o) & ISO_MASK[d]) != ISO_MASK[d]) && !$past(bw_iso)
                |-> ((pwr_dn_o & PWR_MASK[d]) == '0 &&
                     (rst_n_o & RST_MASK[d]) == RST_MASK[d]));
        end
    end
endmodule

bind pwr_domain_seq pds_checker #(
    .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W),
    .PWR_MASK(PWR_MASK), .ISO_MASK(ISO_MASK), .RST_MASK(RST_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .pwr_dn_o(pwr_dn_o), .iso_n_o(iso_n_o),
    .rst_n_o(rst_n_o), .act_vec(act_vec), .dom_busy(dom_busy)
);

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 3;
    localparam logic [ND-1:0][31:0] B_PWR = {32'h0000_0001, 32'h0000_0004, 32'h0000_0008};
    localparam logic [ND-1:0][31:0] B_ISO = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001};
    localparam logic [ND-1:0][31:0] B_RST = {32'h0000_0000, 32'h0004_0000, 32'h0001_0000};

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [ND-1:0] req_vld = 0, req_on = 0;
    logic [31:0] pwr_dn, iso_n, rst_ln;
    logic [ND-1:0] dom_busy, dom_powered;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_domain_seq #(.NUM_DOM(ND), .PWR_MASK(B_PWR), .ISO_MASK(B_ISO), .RST_MASK(B_RST))
    u_pwr_domain_seq (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_vld(req_vld), .req_on(req_on), .pwr_dn_o(pwr_dn), .iso_n_o(iso_n),
        .rst_n_o(rst_ln), .dom_busy(dom_busy), .dom_powered(dom_powered)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    // Run one sequence and check order, spacing, final words and status.
    task automatic run_seq(input int d, input bit on, input int dly);
        logic [31:0] p0, i0, r0, pp, ip, rp;
        int cyc, tp, ti, tr;
        bus_write(8'h20, dly);
        p0 = pwr_dn; i0 = iso_n; r0 = rst_ln;
        pp = p0; ip = i0; rp = r0;
        @(negedge clk); req_vld[d] = 1; req_on[d] = on;
        @(negedge clk); req_vld[d] = 0;
        chk(dom_busy[d] == 1'b1, "R12 busy after request", dom_busy, 1 << d);
        cyc = 0; tp = -1; ti = -1; tr = -1;
        while (dom_busy[d] && cyc < 500) begin
            @(negedge clk); cyc++;
            if ((pwr_dn ^ pp) != 0) tp = cyc;
            if ((iso_n ^ ip) != 0)  ti = cyc;
            if ((rst_ln ^ rp) != 0) tr = cyc;
            pp = pwr_dn; ip = iso_n; rp = rst_ln;
        end
        if (on) begin
            chk(pwr_dn == (p0 & ~B_PWR[d]), "R4/R7 power word after on", pwr_dn, p0 & ~B_PWR[d]);
            chk(iso_n == (i0 | B_ISO[d]), "R4/R7 isolation word after on", iso_n, i0 | B_ISO[d]);
            chk(rst_ln == (r0 | B_RST[d]), "R4/R7 reset word after on", rst_ln, r0 | B_RST[d]);
            chk(dom_powered[d] == 1'b1, "R10 powered after on", dom_powered, 1 << d);
        end else begin
            chk(pwr_dn == (p0 | B_PWR[d]), "R3/R7 power word after off", pwr_dn, p0 | B_PWR[d]);
            chk(iso_n == (i0 & ~B_ISO[d]), "R3/R7 isolation word after off", iso_n, i0 & ~B_ISO[d]);
            chk(rst_ln == (r0 & ~B_RST[d]), "R3/R7 reset word after off", rst_ln, r0 & ~B_RST[d]);
            chk(dom_powered[d] == 1'b0, "R10 unpowered after off", dom_powered, 0);
        end
        if (B_ISO[d] != 0 && B_RST[d] != 0) begin
            if (on) begin
                chk(tp >= 0 && tr > tp && ti > tr, "R4 on order", tr, tp + 1);
                chk(tr - tp == dly + 1, "R5 spacing power to reset", tr - tp, dly + 1);
                chk(ti - tr == dly + 1, "R5 spacing reset to isolation", ti - tr, dly + 1);
            end else begin
                chk(ti >= 0 && tr > ti && tp > tr, "R3 off order", tr, ti + 1);
                chk(tr - ti == dly + 1, "R5 spacing isolation to reset", tr - ti, dly + 1);
                chk(tp - tr == dly + 1, "R5 spacing reset to power", tp - tr, dly + 1);
            end
        end else begin
            chk(ti == -1 && tr == -1, "R6 skipped steps untouched", ti, -1);
            chk(tp > 0, "R6 power step runs", tp, 1);
        end
        chk(dom_busy == 0, "R12 busy cleared", dom_busy, 0);
    endtask

    // Request a state the domain already has: nothing changes.
    task automatic run_same(input int d, input bit on);
        logic [31:0] p0, i0, r0;
        p0 = pwr_dn; i0 = iso_n; r0 = rst_ln;
        @(negedge clk); req_vld[d] = 1; req_on[d] = on;
        @(negedge clk); req_vld[d] = 0;
        repeat (3) @(negedge clk);
        chk(dom_busy == 0, "R9 already-in-state finishes", dom_busy, 0);
        chk(pwr_dn == p0 && iso_n == i0 && rst_ln == r0, "R9 registers unchanged", pwr_dn ^ p0, 0);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int f0, l0, f1, cyc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(pwr_dn == 32'h0, "R1 power word reset", pwr_dn, 0);
        chk(iso_n == 32'hFFFF_FFFF, "R1 isolation word reset", iso_n, 32'hFFFF_FFFF);
        chk(rst_ln == 32'hFFFF_FFFF, "R1 reset word reset", rst_ln, 32'hFFFF_FFFF);
        chk(dom_powered == 3'b111 && dom_busy == 0, "R1 status reset", {dom_powered, dom_busy}, 6'b111000);
        bus_read(8'h20, rd);
        chk(rd == 4, "R1 delay reset", rd, 4);
        // R2 bus access
        bus_read(8'h58, rd); chk(rd == 32'hFFFF_FFFF, "R2 read isolation", rd, 32'hFFFF_FFFF);
        bus_read(8'h30, rd); chk(rd == 32'hFFFF_FFFF, "R2 read reset", rd, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'h8000_0000);
        bus_read(8'h10, rd); chk(rd == 32'h8000_0000, "R2 write/read power", rd, 32'h8000_0000);
        bus_read(8'h00, rd); chk(rd == 0, "R2 unmapped read", rd, 0);
        bus_write(8'h58, 32'h7FFF_FFFF);
        chk(iso_n == 32'h7FFF_FFFF, "R2 isolation write next cycle", iso_n, 32'h7FFF_FFFF);
        bus_write(8'h58, 32'hFFFF_FFFF);
        // R10 powered follows bus writes
        bus_write(8'h10, 32'h0000_0004);
        chk(dom_powered == 3'b101, "R10 powered from bus write", dom_powered, 3'b101);
        bus_write(8'h10, 32'h0);
        chk(dom_powered == 3'b111, "R10 powered restored", dom_powered, 3'b111);
        // R11 reset pulse on an unowned line
        bus_write(8'h34, 32'd7);
        chk(rst_ln == ~(32'h1 << 7), "R11 pulse low", rst_ln, ~(32'h1 << 7));
        @(negedge clk);
        chk(rst_ln == 32'hFFFF_FFFF, "R11 pulse released", rst_ln, 32'hFFFF_FFFF);
        // Sweep: every domain, both directions, delays 0..4
        for (int d = 0; d < ND; d++) begin
            for (int dl = 0; dl <= 4; dl++) begin
                run_seq(d, 1'b0, dl);
                if (dl == 0) run_same(d, 1'b0);
                run_seq(d, 1'b1, dl);
                if (dl == 0) run_same(d, 1'b1);
            end
        end
        // R8 priority: domains 1 and 0 requested together
        bus_write(8'h20, 32'd2);
        @(negedge clk); req_vld = 3'b011; req_on = 3'b000;
        @(negedge clk); req_vld = 0;
        f0 = -1; l0 = -1; f1 = -1; cyc = 0;
        while (dom_busy != 0 && cyc < 500) begin
            @(negedge clk); cyc++;
            if (((pwr_dn & B_PWR[0]) | (~iso_n & B_ISO[0]) | (~rst_ln & B_RST[0])) != 0 && f0 < 0) f0 = cyc;
            if ((pwr_dn & B_PWR[0]) != 0 && l0 < 0) l0 = cyc;
            if (((pwr_dn & B_PWR[1]) | (~iso_n & B_ISO[1]) | (~rst_ln & B_RST[1])) != 0 && f1 < 0) f1 = cyc;
        end
        chk(f0 > 0 && f1 > f0, "R8 lowest index first", f1, f0 + 1);
        chk(f1 > l0 + 2, "R8 one domain at a time", f1, l0 + 3);
        chk(pwr_dn == 32'h0000_000C, "R8 both domains off", pwr_dn, 32'h0000_000C);
        @(negedge clk); req_vld = 3'b011; req_on = 3'b011;
        @(negedge clk); req_vld = 0;
        cyc = 0;
        while (dom_busy != 0 && cyc < 500) begin @(negedge clk); cyc++; end
        chk(pwr_dn == 0 && iso_n == 32'hFFFF_FFFF && rst_ln == 32'hFFFF_FFFF,
            "R8 both domains back on", pwr_dn, 0);
        summary();
        $finish;
    end
endmodule